// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block is a register-mapped front end for a fuse store arranged as banks of eight 32-bit words. Software reaches it over a simple synchronous word-addressed bus, with single-cycle writes and a combinational read path. Through that bus it can read a copy of each fuse word held in shadow registers. It can also overwrite those shadow copies, which never touches the fuses. It can also sense a fuse word directly into a read-data register, or burn new bits into a fuse word. Burning only happens once a 16-bit unlock key has been loaded.

The fuse store is modelled as registers whose bits can only be set: programming ORs the data into the addressed word. Sense and program pulses are timed by a sequencer from software-set relax and strobe counts. A strobe of count C with relax R keeps the busy flag high for R+1 setup cycles, then the remaining strobe cycles (at least one), then R+1 hold cycles. In total that is max(C+1, 2R+3) cycles. The shadow registers are separate from the fuse store and are not refreshed by programming. A sticky error flag records rejected requests. The asynchronous active-low reset is released synchronously through a two-stage synchronizer.

Register map by word address: 0x00 control, 0x01 control clear alias, 0x02 timing, 0x03 read control, 0x04 program data, 0x05 read data, and 0x80 plus the word index for the shadow window. Control layout: bits 6:0 direct address (bank*8+word), bit 8 busy (read-only), bit 9 error (read-only), bits 31:16 unlock field. Timing layout: bits 11:0 program strobe count, bits 15:12 relax count, bits 21:16 sense strobe count.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control, timing and read-data registers read 0, with busy (control bit 8) and error (control bit 9) low.
- R2: A write to shadow address 0x80+i makes later reads of that address return the written value and leaves fuse word i unchanged, as seen by a later sense.
- R3: Writing 1 to bit 0 of read control (0x03) starts a sense of the word addressed by control bits 6:0. When busy clears, read data (0x05) holds that fuse word. Writing read control with bit 0 at 0 starts nothing.
- R4: Writing program data (0x04) while control bits 31:16 hold 0x3E77 ORs the written value into the addressed fuse word, so fuse bits only go from 0 to 1.
- R5: A program-data write without the key 0x3E77 sets the error flag, starts no operation and leaves the fuse word unchanged.
- R6: A sense or program request made while busy is high sets the error flag and has no other effect: the running operation finishes as before and read data is not changed by the rejected request.
- R7: The error flag stays set until a write to the clear alias (0x01) with bit 9 set. Writes to the control register do not clear it.
- R8: Each operation keeps busy high for (R+1) + max(C+1-2(R+1), 1) + (R+1) cycles. Here R is timing bits 15:12, and C is timing bits 21:16 for a sense or bits 11:0 for a program.
- R9: The unlock field reads 0 once a program operation has completed.
- R10: Programming does not reload the shadow registers; a shadow read of a programmed word still returns its previous shadow value.
- R11: A sense or program request whose direct address is not below the number of implemented words sets the error flag and starts no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Bus access strobe for the current cycle |
| bus_wr | input | 1 | 1 for a write access, 0 for a read |
| bus_addr | input | 8 | Word address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench uses the default of four banks, so 32 words are implemented. That makes address 0x1F the last valid word and 0x20 the first out-of-range one. Both sides of the address boundary are therefore reachable with a 7-bit field. The timing register is loaded with a small relax count and short strobe counts. This keeps every operation to a few tens of cycles. It also covers both branches of the busy-length formula: a strobe longer than the setup and hold, and one shorter, where the active phase is clamped to one cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0]  REG_CTRL     = 8'h00;
  localparam logic [7:0]  REG_CTRL_CLR = 8'h01;
  localparam logic [7:0]  REG_TIMING   = 8'h02;
  localparam logic [7:0]  REG_RDCTL    = 8'h03;
  localparam logic [7:0]  REG_PDATA    = 8'h04;
  localparam logic [7:0]  REG_RDATA    = 8'h05;
  localparam logic [15:0] UNLOCK_KEY   = 16'h3E77;
  localparam int          WORD_W       = 32;
  localparam int          WORDS_PER_BANK = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/otp_rst_sync.sv
module otp_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/otp_strobe_seq.sv
module otp_strobe_seq
  import otp_pkg::*;
#(
  parameter int RELAX_W = 4,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RELAX_W-1:0] relax_i,
  input  logic [CNT_W-1:0]   count_i,
  output logic               busy_o,
  output logic               done_o
);
  localparam int SUM_W = CNT_W + 1;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RELAX_W-1:0] relax_q;
  logic [CNT_W-1:0]   act_q;
  logic [SUM_W-1:0]   edge_sum;
  logic [CNT_W-1:0]   act_d;
  logic               load_en;

  // setup + hold together take 2*(relax+1) cycles of the strobe
  assign edge_sum = {{(SUM_W-RELAX_W-1){1'b0}}, relax_i, 1'b0} + SUM_W'(2);
  always_comb begin
    if ({1'b0, count_i} >= edge_sum) act_d = CNT_W'({1'b0, count_i} - edge_sum);
    else                             act_d = '0;
  end

  assign load_en = start_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SETUP;
          cnt_d   = CNT_W'(relax_i);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACTIVE;
          cnt_d   = act_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = CNT_W'(relax_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_o  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relax_q <= '0;
      act_q   <= '0;
    end else if (load_en) begin
      relax_q <= relax_i;
      act_q   <= act_d;
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
  parameter int NUM_WORDS = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        burn_en,
  input  logic [IDX_W-1:0]            burn_idx,
  input  logic [DATA_W-1:0]           burn_data,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_WORDS*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] cell_q [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_cell
    logic hit;
    assign hit = burn_en && (burn_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q[i] <= '0;
      else if (hit) cell_q[i] <= cell_q[i] | burn_data;
    end
    assign flat_o[i*DATA_W +: DATA_W] = cell_q[i];
  end

  assign rd_data = cell_q[rd_idx];
endmodule

// File: rtl/otp_shadow_bank.sv
module otp_shadow_bank #(
  parameter int NUM_WORDS = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sh_q [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sh
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sh_q[i] <= '0;
      else if (hit) sh_q[i] <= wr_data;
    end
  end

  assign rd_data = sh_q[rd_idx];
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 8,
  parameter int RELAX_W   = 4,
  parameter int PSTRB_W   = 12,
  parameter int RSTRB_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int NUM_WORDS = NUM_BANKS * WORDS_PER_BANK;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int DADDR_W   = 7;

  logic rst_n_int;

  otp_rst_sync u_rst (.clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int));

  // ---------------- state ----------------
  logic [DADDR_W-1:0] daddr_q, daddr_d;
  logic [15:0]        key_q, key_d;
  logic               err_q, err_d;
  logic [PSTRB_W-1:0] tprog_q;
  logic [RELAX_W-1:0] trelax_q;
  logic [RSTRB_W-1:0] tread_q;
  logic [31:0]        rdata_q;
  logic               op_prog_q;
  logic [IDX_W-1:0]   op_idx_q;
  logic [31:0]        op_data_q;

  // ---------------- bus decode ----------------
  logic acc_wr, wr_ctrl, wr_clr, wr_tim, wr_rdctl, wr_pdata, wr_shadow;
  logic shadow_hit_rd;
  logic [DADDR_W-1:0] win_off;

  assign acc_wr    = bus_sel && bus_wr;
  assign wr_ctrl   = acc_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_clr    = acc_wr && (bus_addr == ADDR_W'(REG_CTRL_CLR));
  assign wr_tim    = acc_wr && (bus_addr == ADDR_W'(REG_TIMING));
  assign wr_rdctl  = acc_wr && (bus_addr == ADDR_W'(REG_RDCTL));
  assign wr_pdata  = acc_wr && (bus_addr == ADDR_W'(REG_PDATA));
  assign win_off   = bus_addr[DADDR_W-1:0];
  assign shadow_hit_rd = bus_addr[ADDR_W-1] &&
                         ({1'b0, win_off} < (DADDR_W+1)'(NUM_WORDS));
  assign wr_shadow = acc_wr && shadow_hit_rd;

  // ---------------- request arbitration ----------------
  logic sense_req, prog_req, any_req, addr_bad, key_ok, busy, done, reject, launch;

  assign sense_req = wr_rdctl && bus_wdata[0];
  assign prog_req  = wr_pdata;
  assign any_req   = sense_req || prog_req;
  assign addr_bad  = ({1'b0, daddr_q} >= (DADDR_W+1)'(NUM_WORDS));
  assign key_ok    = (key_q == UNLOCK_KEY);
  assign reject    = any_req && (busy || addr_bad || (prog_req && !key_ok));
  assign launch    = any_req && !reject;

  // ---------------- control register next state ----------------
  always_comb begin
    daddr_d = daddr_q;
    key_d   = key_q;
    err_d   = err_q;
    if (wr_ctrl) begin
      daddr_d = bus_wdata[DADDR_W-1:0];
      key_d   = bus_wdata[31:16];
    end
    if (wr_clr) begin
      daddr_d = daddr_q & ~bus_wdata[DADDR_W-1:0];
      key_d   = key_q & ~bus_wdata[31:16];
      if (bus_wdata[9]) err_d = 1'b0;
    end
    if (reject) err_d = 1'b1;
    if (done && op_prog_q) key_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      daddr_q <= '0;
      key_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      daddr_q <= daddr_d;
      key_q   <= key_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      tprog_q  <= '0;
      trelax_q <= '0;
      tread_q  <= '0;
    end else if (wr_tim) begin
      tprog_q  <= bus_wdata[PSTRB_W-1:0];
      trelax_q <= bus_wdata[12 +: RELAX_W];
      tread_q  <= bus_wdata[16 +: RSTRB_W];
    end
  end

  // ---------------- operation latch ----------------
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      op_prog_q <= 1'b0;
      op_idx_q  <= '0;
      op_data_q <= '0;
    end else if (launch) begin
      op_prog_q <= prog_req;
      op_idx_q  <= IDX_W'(daddr_q);
      op_data_q <= bus_wdata;
    end
  end

  // ---------------- strobe sequencer ----------------
  logic [PSTRB_W-1:0] strobe_len;
  assign strobe_len = prog_req ? tprog_q : PSTRB_W'(tread_q);

  otp_strobe_seq #(.RELAX_W(RELAX_W), .CNT_W(PSTRB_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (launch),
    .relax_i (trelax_q),
    .count_i (strobe_len),
    .busy_o  (busy),
    .done_o  (done)
  );

  // ---------------- fuse store and shadows ----------------
  logic [31:0]             fuse_rd, shadow_rd;
  logic [NUM_WORDS*32-1:0] fuse_flat;

  otp_fuse_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(32)) u_fuse (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .burn_en   (done && op_prog_q),
    .burn_idx  (op_idx_q),
    .burn_data (op_data_q),
    .rd_idx    (op_idx_q),
    .rd_data   (fuse_rd),
    .flat_o    (fuse_flat)
  );

  otp_shadow_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(32)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_shadow),
    .wr_idx  (IDX_W'(win_off)),
    .wr_data (bus_wdata),
    .rd_idx  (IDX_W'(win_off)),
    .rd_data (shadow_rd)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)              rdata_q <= '0;
    else if (done && !op_prog_q) rdata_q <= fuse_rd;
  end

  // ---------------- read mux ----------------
  logic [31:0] ctrl_view, tim_view;
  assign ctrl_view = {key_q, 6'b0, err_q, busy, 1'b0, daddr_q};
  assign tim_view  = {{(32-16-RSTRB_W){1'b0}}, tread_q, trelax_q, tprog_q};

  always_comb begin
    bus_rdata = '0;
    if (shadow_hit_rd) bus_rdata = shadow_rd;
    else begin
      case (bus_addr)
        ADDR_W'(REG_CTRL), ADDR_W'(REG_CTRL_CLR): bus_rdata = ctrl_view;
        ADDR_W'(REG_TIMING): bus_rdata = tim_view;
        ADDR_W'(REG_RDATA):  bus_rdata = rdata_q;
        default:             bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int FLAT_W = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              op_prog,
  input logic              sense_req,
  input logic              prog_req,
  input logic              err,
  input logic              clr_err,
  input logic [15:0]       key,
  input logic [FLAT_W-1:0] fuse_flat
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4: fuse bits never return to zero
  p_fuse_only_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(fuse_flat) & ~fuse_flat) == '0));

  // R2: fuse store cannot change unless an operation is running
  p_fuse_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(fuse_flat));

  // R5: a program request without the key is refused and flagged
  p_nokey_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !busy && key != 16'h3E77) |=> (err && !busy));

  // R6: any request while busy is flagged
  p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (sense_req || prog_req)) |=> err);

  // R7: error stays until the clear alias is written
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_err) |=> err);

  // R9: unlock field is empty after a program completes
  p_key_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_prog) |=> (key == 16'h0000));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.FLAT_W(NUM_WORDS*32)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .busy      (busy),
  .done      (done),
  .op_prog   (op_prog_q),
  .sense_req (sense_req),
  .prog_req  (prog_req),
  .err       (err_q),
  .clr_err   (wr_clr && bus_wdata[9]),
  .key       (key_q),
  .fuse_flat (fuse_flat)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  localparam logic [15:0] KEY = 16'h3E77;
  // timing: prog strobe 20, relax 1, sense strobe 9
  localparam logic [31:0] TIM_VAL = 32'h0009_1014;
  localparam int PROG_CYC  = 21;
  localparam int SENSE_CYC = 10;
  localparam int NVEC = 6;
  // {addr[6:0], data[31:0], expected fuse word[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {7'h00, 32'h0000_00F0, 32'h0000_00F0},
    {7'h00, 32'h0000_0F0F, 32'h0000_0FFF},
    {7'h09, 32'hA5A5_0000, 32'hA5A5_0000},
    {7'h1F, 32'h8000_0001, 32'h8000_0001},
    {7'h09, 32'h0000_5A5A, 32'hA5A5_5A5A},
    {7'h12, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks;
  int fails;

  otp_fuse_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      bus_read(8'h00, v);
      if (!v[8]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_prog(input logic [6:0] a, input logic [31:0] d, output int n);
    bus_write(8'h00, {KEY, 9'b0, a});
    bus_write(8'h04, d);
    wait_idle(n);
  endtask

  task automatic do_sense(input logic [6:0] a, output logic [31:0] d, output int n);
    bus_write(8'h00, {16'h0, 9'b0, a});
    bus_write(8'h03, 32'h1);
    wait_idle(n);
    bus_read(8'h05, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    checks = 0; fails = 0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(8'h00, v); check("R1 ctrl", v, 32'h0);
    bus_read(8'h02, v); check("R1 timing", v, 32'h0);
    bus_read(8'h05, v); check("R1 rdata", v, 32'h0);

    bus_write(8'h02, TIM_VAL);
    bus_read(8'h02, v); check("R8 timing readback", v, TIM_VAL);

    // table: program, then sense and compare (R4, R3, R8, R9)
    for (int i = 0; i < NVEC; i++) begin
      logic [6:0]  a;
      logic [31:0] d, e;
      {a, d, e} = VEC[i];
      do_prog(a, d, n);
      check("R8 prog busy cycles", n, PROG_CYC);
      bus_read(8'h00, v); check("R9 key cleared", {16'h0, v[31:16]}, 32'h0);
      do_sense(a, v, n);
      check("R4 fuse OR content", v, e);
      check("R8 sense busy cycles", n, SENSE_CYC);
    end

    // R10 shadows not reloaded by programming
    bus_read(8'h89, v); check("R10 shadow stale", v, 32'h0);
    bus_read(8'h9F, v); check("R10 shadow stale last", v, 32'h0);

    // R2 override
    bus_write(8'h83, 32'hDEAD_BEEF);
    bus_read(8'h83, v); check("R2 shadow readback", v, 32'hDEAD_BEEF);
    do_sense(7'h03, v, n); check("R2 fuse untouched", v, 32'h0);

    // R3 read control with bit 0 clear starts nothing
    bus_write(8'h00, {16'h0, 9'b0, 7'h00});
    bus_write(8'h03, 32'h2);
    bus_read(8'h00, v); check("R3 no start busy", {31'h0, v[8]}, 32'h0);
    bus_read(8'h05, v); check("R3 rdata kept", v, 32'h0);

    // R5 program without key
    bus_write(8'h00, {16'h1234, 9'b0, 7'h05});
    bus_write(8'h04, 32'h0000_00FF);
    bus_read(8'h00, v);
    check("R5 error set", {31'h0, v[9]}, 32'h1);
    check("R5 not busy", {31'h0, v[8]}, 32'h0);
    do_sense(7'h05, v, n); check("R5 fuse unchanged", v, 32'h0);

    // R7 sticky error, control write does not clear, alias does
    bus_write(8'h00, {16'h0, 9'b0, 7'h01});
    bus_read(8'h00, v); check("R7 still set", {31'h0, v[9]}, 32'h1);
    bus_write(8'h01, 32'h0000_0200);
    bus_read(8'h00, v); check("R7 cleared", {31'h0, v[9]}, 32'h0);

    // R6 request while busy
    bus_write(8'h00, {KEY, 9'b0, 7'h06});
    bus_write(8'h04, 32'h0000_0001);
    bus_write(8'h03, 32'h1);
    bus_read(8'h00, v); check("R6 error on busy", {31'h0, v[9]}, 32'h1);
    wait_idle(n);
    check("R6 prog runs unchanged", n, PROG_CYC - 1);
    bus_read(8'h05, v); check("R6 rdata unchanged", v, 32'h0);
    do_sense(7'h06, v, n); check("R6 prog completed", v, 32'h1);
    bus_write(8'h01, 32'h0000_0200);

    // R11 address out of range
    bus_write(8'h00, {16'h0, 9'b0, 7'h20});
    bus_write(8'h03, 32'h1);
    bus_read(8'h00, v);
    check("R11 error set", {31'h0, v[9]}, 32'h1);
    check("R11 not busy", {31'h0, v[8]}, 32'h0);
    bus_write(8'h01, 32'h0000_0200);

    // R8 short strobes: clamped active phase
    bus_write(8'h02, 32'h0002_1000);
    do_sense(7'h00, v, n); check("R8 short sense cycles", n, 5);
    check("R3 sense word 0", v, 32'h0000_0FFF);
    bus_write(8'h02, 32'h0000_0000);
    do_sense(7'h1F, v, n); check("R8 minimal cycles", n, 3);
    check("R3 sense word 31", v, 32'h8000_0001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule